// File: doc/BRIEF.md
# Host-to-Controller Byte Mailbox

This block sits on a host register bus and carries single bytes between the host and a small controller on its far side. The host pushes outgoing bytes into a transmit queue and pops incoming bytes from a receive queue. Both moves go through one data word, with the byte in bits 15:8. Two more words let software watch the queues: a status word with live and sticky conditions, and an interrupt word with a per-condition arm bit and enable bit.

On the far side the transmit queue presents a byte with a valid/ready handshake. The receive queue takes one byte on every cycle that its valid strobe is high. When the receive queue is full, an incoming byte is lost and a sticky overflow flag records the loss. A single level interrupt output is raised while any armed and enabled condition holds.

Top module: `mbox_host_if`

## Requirements
- R1: After reset the status word reads 0x3, the interrupt word reads 0, `irq` is low and `tx_valid` is low.
- R2: Word addresses are byte offsets 0x0 (interrupt), 0x4 (data) and 0x8 (status). The remaining words of the window read 0, and writes to them change nothing.
- R3: A data-word write queues wdata[15:8] for transmission. Bytes leave on `tx_byte` in write order, one per cycle with `tx_valid` and `tx_ready` both high.
- R4: Status bits are: bit 0 transmit queue empty, bit 1 transmit queue not full, bit 2 receive queue not empty, bit 3 receive overflow (sticky). Bits 31:4 read 0.
- R5: Each queue holds 16 bytes. A data write while the transmit queue is full is dropped.
- R6: A byte that arrives while the receive queue is full is dropped and sets status bit 3.
- R7: A status write clears status bit 3 when wdata bit 3 is 1. Writing 0 there leaves it set.
- R8: Interrupt word bits 7:4 are enables and bits 3:0 are arm bits for the four status conditions, in status bit order. Bits 3:0 read as condition AND arm. `irq` is high exactly when some condition is armed, enabled and true.
- R9: A data-word read with the receive queue empty returns 0 and removes nothing.
- R10: A data-word read returns the oldest received byte in bits 15:8 (other bits 0) and removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 5 | Byte address in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tx_byte | output | 8 | Oldest queued outgoing byte |
| tx_valid | output | 1 | Outgoing byte available |
| tx_ready | input | 1 | Far side takes the outgoing byte |
| rx_byte | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte strobe |
| irq | output | 1 | Level interrupt request |

## Verification
The transmit path is driven with short bursts and with 17 writes, so that order loss and overfill are told apart. The receive path gets partial fills, an exact fill plus one extra byte, and reads past empty. These separate a dropped byte, a duplicated pop and a missing overflow mark. The interrupt word is tried with condition true and false and with the enable on and off, which shows whether arm, enable and condition are each needed. Reserved words and zero-valued status writes show that unrelated accesses leave state alone.

// File: rtl/mbox_host_if.sv
module mbox_host_if #(
  parameter int AW    = 5,
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic [DW-1:0] tx_byte,
  output logic          tx_valid,
  input  logic          tx_ready,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_valid,
  output logic          irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int IW = AW - 2;
  localparam logic [IW-1:0] A_INT  = IW'(0);
  localparam logic [IW-1:0] A_DATA = IW'(1);
  localparam logic [IW-1:0] A_STAT = IW'(2);

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [PW-1:0] tx_rp, tx_wp, rx_rp, rx_wp;
  logic [PW:0]   tx_cnt, rx_cnt;
  logic          rxo;
  logic [3:0]    arm_q, mask_q;

  wire [IW-1:0] idx  = bus_addr[AW-1:2];
  wire tx_empty      = tx_cnt == '0;
  wire tx_full       = tx_cnt == (PW+1)'(DEPTH);
  wire rx_empty      = rx_cnt == '0;
  wire rx_full       = rx_cnt == (PW+1)'(DEPTH);
  wire wr_int        = bus_sel &  bus_wr & idx == A_INT;
  wire wr_data       = bus_sel &  bus_wr & idx == A_DATA;
  wire wr_stat       = bus_sel &  bus_wr & idx == A_STAT;
  wire rd_data       = bus_sel & !bus_wr & idx == A_DATA;
  wire tx_push       = wr_data & !tx_full;
  wire tx_pop        = tx_valid & tx_ready;
  wire rx_pop        = rd_data & !rx_empty;
  wire rx_push       = rx_valid & (!rx_full | rx_pop);
  wire rx_drop       = rx_valid & rx_full & !rx_pop;
  wire [3:0] cond    = {rxo, !rx_empty, !tx_full, tx_empty};

  assign tx_valid = !tx_empty;
  assign tx_byte  = tx_mem[tx_rp];
  assign irq      = |(cond & arm_q & mask_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (idx)
        A_INT:   bus_rdata[7:0] = {mask_q, cond & arm_q};
        A_DATA:  if (!rx_empty) bus_rdata[15:8] = rx_mem[rx_rp];
        A_STAT:  bus_rdata[3:0] = cond;
        default: bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[15:8];
    if (rx_push) rx_mem[rx_wp] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_rp  <= '0;
      tx_wp  <= '0;
      tx_cnt <= '0;
      rx_rp  <= '0;
      rx_wp  <= '0;
      rx_cnt <= '0;
      rxo    <= 1'b0;
      arm_q  <= '0;
      mask_q <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + (PW+1)'(tx_push) - (PW+1)'(tx_pop);
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + (PW+1)'(rx_push) - (PW+1)'(rx_pop);
      if (rx_drop)                     rxo <= 1'b1;
      else if (wr_stat && bus_wdata[3]) rxo <= 1'b0;
      if (wr_int) begin
        arm_q  <= bus_wdata[3:0];
        mask_q <= bus_wdata[7:4];
      end
    end
  end
endmodule

module mbox_host_if_chk #(
  parameter int AW = 5,
  parameter int PW = 4,
  parameter int DEPTH = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic          tx_ready,
  input logic          tx_valid,
  input logic          irq,
  input logic [PW:0]   tx_cnt,
  input logic [PW:0]   rx_cnt,
  input logic          rxo,
  input logic [3:0]    mask_q
);
  wire data_acc = bus_sel && bus_addr[AW-1:2] == (AW-2)'(1);
  wire stat_w1  = bus_sel && bus_wr && bus_addr[AW-1:2] == (AW-2)'(2) && bus_wdata[3];

  AST_TX_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == (PW+1)'(DEPTH) && data_acc && bus_wr && !tx_ready) |=> tx_cnt == (PW+1)'(DEPTH)); // R5
  AST_RXO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rxo && !stat_w1) |=> rxo); // R7
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == '0 && data_acc && !bus_wr) |-> bus_rdata == 32'h0); // R9
  AST_EMPTY_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == '0 && data_acc && !bus_wr) |=> rx_cnt <= 1); // R9
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 4'h0) |-> !irq); // R8
  AST_TX_VALID_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid == (tx_cnt != '0)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= (PW+1)'(DEPTH) && rx_cnt <= (PW+1)'(DEPTH)); // R5
endmodule

bind mbox_host_if mbox_host_if_chk #(.AW(AW), .PW(PW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .tx_ready(tx_ready), .tx_valid(tx_valid), .irq(irq),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .rxo(rxo), .mask_q(mask_q)
);

// File: tb/tb_mbox_host_if.sv
module tb_mbox_host_if;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [4:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [7:0] tx_byte, rx_byte = 0;
  logic tx_valid, tx_ready = 0, rx_valid = 0, irq;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  mbox_host_if dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #5 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_byte = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(5'h8, d); chk("R1 status", d, 32'h3);
    rd(5'h0, d); chk("R1 intr", d, 32'h0);
    chk("R1 irq", irq, 0);
    chk("R1 tx_valid", tx_valid, 0);
  endtask

  task automatic t_tx_order;
    logic [31:0] d;
    wr(5'h4, 32'hFFFF_A5FF); wr(5'h4, 32'h0000_3C00); wr(5'h4, 32'h0000_7100);
    rd(5'h8, d); chk("R4 tx partial status", d, 32'h2);
    @(negedge clk); tx_ready = 1;
    #1 chk("R3 byte0", tx_byte, 8'hA5);
    @(negedge clk); #1 chk("R3 byte1", tx_byte, 8'h3C);
    @(negedge clk); #1 chk("R3 byte2", tx_byte, 8'h71);
    @(negedge clk); tx_ready = 0;
    #1 chk("R3 drained", tx_valid, 0);
  endtask

  task automatic t_tx_full;
    logic [31:0] d;
    for (int i = 0; i < 17; i++) wr(5'h4, {16'h0, 8'(i + 8'h40), 8'h0});
    rd(5'h8, d); chk("R5 full status", d, 32'h0);
    @(negedge clk); tx_ready = 1;
    for (int i = 0; i < 16; i++) begin
      #1 chk("R5 drain order", tx_byte, 8'(i + 8'h40));
      @(negedge clk);
    end
    tx_ready = 0;
    #1 chk("R5 extra dropped", tx_valid, 0);
  endtask

  task automatic t_rx_basic;
    logic [31:0] d;
    rx_push(8'h9E); rx_push(8'h12);
    rd(5'h8, d); chk("R4 rx status", d, 32'h7);
    rd(5'h4, d); chk("R10 first", d, 32'h0000_9E00);
    rd(5'h4, d); chk("R10 second", d, 32'h0000_1200);
    rd(5'h4, d); chk("R9 empty read", d, 32'h0);
    rx_push(8'h55);
    rd(5'h4, d); chk("R9 no pop on empty", d, 32'h0000_5500);
    rd(5'h8, d); chk("R4 back idle", d, 32'h3);
  endtask

  task automatic t_overflow;
    logic [31:0] d;
    for (int i = 0; i < 17; i++) rx_push(8'(i + 8'h80));
    rd(5'h8, d); chk("R6 overflow status", d, 32'hF);
    for (int i = 0; i < 16; i++) begin
      rd(5'h4, d); chk("R6 kept order", d, {16'h0, 8'(i + 8'h80), 8'h0});
    end
    rd(5'h4, d); chk("R6 extra dropped", d, 32'h0);
    wr(5'h8, 32'h0000_0007);
    rd(5'h8, d); chk("R7 sticky", d, 32'hB);
    wr(5'h8, 32'h0000_0008);
    rd(5'h8, d); chk("R7 w1c", d, 32'h3);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(5'h0, 32'h44);
    #1 chk("R8 no cond", irq, 0);
    rd(5'h0, d); chk("R8 intr read idle", d, 32'h40);
    rx_push(8'h01);
    #1 chk("R8 rx irq", irq, 1);
    rd(5'h0, d); chk("R8 intr read req", d, 32'h44);
    wr(5'h0, 32'h04);
    #1 chk("R8 disabled", irq, 0);
    wr(5'h0, 32'h40);
    #1 chk("R8 unarmed", irq, 0);
    wr(5'h0, 32'h44);
    rd(5'h4, d);
    #1 chk("R8 cleared by pop", irq, 0);
    wr(5'h0, 32'h11);
    #1 chk("R8 tx empty irq", irq, 1);
    wr(5'h0, 32'h0);
    #1 chk("R8 off", irq, 0);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    wr(5'hC, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    rd(5'hC, d); chk("R2 reserved read", d, 32'h0);
    rd(5'h8, d); chk("R2 status untouched", d, 32'h3);
    rd(5'h0, d); chk("R2 intr untouched", d, 32'h0);
    chk("R2 tx untouched", tx_valid, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset(); t_tx_order(); t_tx_full(); t_rx_basic();
        t_overflow(); t_irq(); t_reserved();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule